// File: doc/BRIEF.md
# Two-Stage Address Window Decoder

This block sits between a bus master and several target controllers. A transaction brings a 36-bit physical address. The first stage compares that address against eight programmable access windows. Each window holds a 24-bit base, a power-of-two size and a 4-bit target identifier. The block then reports which target controller should receive the transaction. If no enabled window covers the address, the block raises a decode error instead.

When the chosen target is the external-bus controller, a second stage runs on the low 32 address bits only. Each of four banks holds a 24-bit base, a 16-bit mask and a valid flag. A bank matches when address bits 31:24 equal its top eight base bits and address bits 23:8, ANDed with the mask, equal its low sixteen base bits ANDed with the same mask. The lowest-numbered matching bank drives its active-low chip-select.

Software programs all windows and banks through a single-cycle write port. Every decode result is registered, so it appears one clock after the address strobe.

Top module: `addr_route_decoder`

## Requirements
- R1: After reset every window is disabled and every bank is invalid. While reset is held, and until the first strobe, `tgt_valid` and `dec_err` are 0, `tgt_id` is 0 and `cs_n` is all ones. A lookup made before any programming returns `dec_err`.
- R2: A window's 24-bit base is formed from its high register (`wr_data[3:0]`, compared with address bits 35:32) and its low register (`wr_data[19:0]`, compared with address bits 31:12). A lookup that hits the window gives `tgt_valid`=1 and `tgt_id` equal to the window's identifier.
- R3: The attribute register holds the enable in bit 0, the size exponent k in bits 5:1 and the target identifier in bits 11:8. The window spans 2^k bytes, and address and base bits below bit k are ignored in the compare. Any k below 12 behaves as 12 (4 KiB).
- R4: A window whose enable bit is 0 never matches.
- R5: When several enabled windows match, the lowest-numbered one decides `tgt_id`.
- R6: A lookup that matches no window gives `dec_err`=1 for one cycle, with `tgt_valid`=0 and `cs_n` all ones.
- R7: A bank matches only if address bits 31:24 equal bits 23:16 of the bank base exactly. The bank base register holds the base in `wr_data[23:0]` and the valid flag in `wr_data[31]`.
- R8: A bank also requires that address bits 23:8 ANDed with the mask (mask register, `wr_data[15:0]`) equal base bits 15:0 ANDed with the mask. Both this compare and the R7 compare must hold.
- R9: Chip-selects are asserted only when the selected window's identifier equals the external-bus identifier (default 1). For every other identifier `cs_n` stays all ones.
- R10: `cs_n` is active-low and at most one bit is low. The lowest-numbered valid matching bank wins, and a bank whose valid flag is 0 never matches.
- R11: Outputs reflect a lookup exactly one cycle after `addr_valid`. A cycle without `addr_valid` is followed by idle outputs. Back-to-back lookups each produce their own result.
- R12: `wr_sel` picks the register: 0 window high, 1 window low, 2 window attribute, 3 bank base, 4 bank mask. `wr_idx` picks the entry. A bank write with `wr_idx` at or beyond the bank count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register kind select |
| wr_idx | input | 3 | Window or bank index |
| wr_data | input | 32 | Write data |
| addr_valid | input | 1 | Lookup strobe |
| addr | input | 36 | Physical address of the lookup |
| tgt_valid | output | 1 | A window matched; `tgt_id` is meaningful |
| tgt_id | output | 4 | Identifier of the selected target |
| dec_err | output | 1 | No window matched |
| cs_n | output | 4 | Active-low one-hot bank chip-selects |

## Verification
The bench targets the edges of each window's span: the last byte inside and the first byte outside. It uses a size code below the 4 KiB floor, which a design without clamping would turn into a window that is too small. Overlapping windows and overlapping banks catch a priority encoder that favours the highest index. A disabled window and an invalid bank that cover live addresses catch a design that forgets the enable or valid qualifiers. An address whose low bits match a bank but whose top byte does not, and one that routes to a non-external target, would wrongly pull a chip-select low if the exact compare or the target gating were missing. An out-of-range bank write would corrupt a real bank if the index were truncated.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
  localparam int ADDR_W   = 36;
  localparam int EXT_W    = 32;
  localparam int PAGE_LSB = 12;
  localparam int WBASE_W  = ADDR_W - PAGE_LSB;
  localparam int TID_W    = 4;
  localparam int SZ_W     = 5;
  localparam int MASK_W   = 16;
  localparam int BBASE_W  = 24;
  localparam int TAG_LSB  = EXT_W - BBASE_W;

  typedef enum logic [2:0] {
    SEL_WIN_HI    = 3'd0,
    SEL_WIN_LO    = 3'd1,
    SEL_WIN_ATTR  = 3'd2,
    SEL_BANK_BASE = 3'd3,
    SEL_BANK_MASK = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic               en;
    logic [SZ_W-1:0]    sz;
    logic [TID_W-1:0]   tid;
    logic [WBASE_W-1:0] base;
  } win_cfg_t;

  typedef struct packed {
    logic               vld;
    logic [BBASE_W-1:0] base;
    logic [MASK_W-1:0]  mask;
  } bank_cfg_t;
endpackage

// File: rtl/arw_win_match.sv
module arw_win_match
  import addr_route_pkg::*;
(
  input  win_cfg_t           cfg,
  input  logic [WBASE_W-1:0] page,
  output logic               hit
);
  logic [SZ_W-1:0]    k_eff;
  logic [WBASE_W-1:0] care;

  always_comb begin
    k_eff = (cfg.sz < SZ_W'(PAGE_LSB)) ? SZ_W'(PAGE_LSB) : cfg.sz;
    for (int j = 0; j < WBASE_W; j++) begin
      care[j] = ((j + PAGE_LSB) >= int'(k_eff));
    end
    hit = cfg.en && (((page ^ cfg.base) & care) == '0);
  end
endmodule

// File: rtl/arw_bank_match.sv
module arw_bank_match
  import addr_route_pkg::*;
(
  input  bank_cfg_t          cfg,
  input  logic [BBASE_W-1:0] tag,
  output logic               hit
);
  localparam int HI_W = BBASE_W - MASK_W;

  logic exact_ok;
  logic masked_ok;

  always_comb begin
    exact_ok  = (tag[BBASE_W-1 -: HI_W] == cfg.base[BBASE_W-1 -: HI_W]);
    masked_ok = (((tag[MASK_W-1:0] ^ cfg.base[MASK_W-1:0]) & cfg.mask) == '0);
    hit       = cfg.vld && exact_ok && masked_ok;
  end
endmodule

// File: rtl/arw_lowest_pick.sv
module arw_lowest_pick #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/addr_route_decoder.sv
module addr_route_decoder
  import addr_route_pkg::*;
#(
  parameter int               NUM_WIN  = 8,
  parameter int               NUM_BANK = 4,
  parameter logic [TID_W-1:0] EXT_TGT  = 4'd1,
  localparam int              WIDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int              BIDX_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [WIDX_W-1:0]   wr_idx,
  input  logic [31:0]         wr_data,
  input  logic                addr_valid,
  input  logic [ADDR_W-1:0]   addr,
  output logic                tgt_valid,
  output logic [TID_W-1:0]    tgt_id,
  output logic                dec_err,
  output logic [NUM_BANK-1:0] cs_n
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel);

  win_cfg_t  win_cfg  [NUM_WIN];
  bank_cfg_t bank_cfg [NUM_BANK];
  logic [NUM_WIN-1:0]  win_hit;
  logic [NUM_BANK-1:0] bank_hit;

  // window configuration and stage-one compare
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel_me;
    assign sel_me = wr_en && (wr_idx == WIDX_W'(w));

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        win_cfg[w] <= '0;
      end else if (sel_me) begin
        if (sel == SEL_WIN_HI)   win_cfg[w].base[WBASE_W-1 -: 4] <= wr_data[3:0];
        if (sel == SEL_WIN_LO)   win_cfg[w].base[WBASE_W-5:0]    <= wr_data[19:0];
        if (sel == SEL_WIN_ATTR) begin
          win_cfg[w].en  <= wr_data[0];
          win_cfg[w].sz  <= wr_data[5:1];
          win_cfg[w].tid <= wr_data[11:8];
        end
      end
    end

    arw_win_match u_win (
      .cfg  (win_cfg[w]),
      .page (addr[ADDR_W-1:PAGE_LSB]),
      .hit  (win_hit[w])
    );
  end

  // bank configuration and stage-two compare
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic sel_me;
    assign sel_me = wr_en && (wr_idx == WIDX_W'(b));

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        bank_cfg[b] <= '0;
      end else if (sel_me) begin
        if (sel == SEL_BANK_BASE) begin
          bank_cfg[b].vld  <= wr_data[31];
          bank_cfg[b].base <= wr_data[BBASE_W-1:0];
        end
        if (sel == SEL_BANK_MASK) bank_cfg[b].mask <= wr_data[MASK_W-1:0];
      end
    end

    arw_bank_match u_bank (
      .cfg (bank_cfg[b]),
      .tag (addr[EXT_W-1:TAG_LSB]),
      .hit (bank_hit[b])
    );
  end

  // priority selection
  logic [NUM_WIN-1:0]  unused_win_gnt;
  logic [WIDX_W-1:0]   win_idx;
  logic                win_any;
  logic [NUM_BANK-1:0] bank_gnt;
  logic [BIDX_W-1:0]   unused_bank_idx;
  logic                unused_bank_any;

  arw_lowest_pick #(.N(NUM_WIN)) u_win_pick (
    .req (win_hit),
    .gnt (unused_win_gnt),
    .idx (win_idx),
    .any (win_any)
  );

  arw_lowest_pick #(.N(NUM_BANK)) u_bank_pick (
    .req (bank_hit),
    .gnt (bank_gnt),
    .idx (unused_bank_idx),
    .any (unused_bank_any)
  );

  logic unused_bits;
  assign unused_bits = ^{wr_data[30:24], addr[PAGE_LSB-1:0]};

  // next-state of the registered outputs
  logic [TID_W-1:0]    sel_tid;
  logic                tv_d, err_d;
  logic [TID_W-1:0]    tid_d;
  logic [NUM_BANK-1:0] cs_n_d;

  always_comb begin
    sel_tid = win_cfg[win_idx].tid;
    tv_d    = addr_valid && win_any;
    err_d   = addr_valid && !win_any;
    tid_d   = tv_d ? sel_tid : '0;
    cs_n_d  = (tv_d && (sel_tid == EXT_TGT)) ? ~bank_gnt : '1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tgt_valid <= 1'b0;
      tgt_id    <= '0;
      dec_err   <= 1'b0;
      cs_n      <= '1;
    end else begin
      tgt_valid <= tv_d;
      tgt_id    <= tid_d;
      dec_err   <= err_d;
      cs_n      <= cs_n_d;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(~cs_n)); // R10
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_q)
    dec_err |-> (!tgt_valid && (cs_n == '1))); // R6
  AST_CS_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_q)
    (cs_n != '1) |-> (tgt_valid && (tgt_id == EXT_TGT))); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q)
    addr_valid |=> (tgt_valid ^ dec_err)); // R11
  AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_q)
    !addr_valid |=> (!tgt_valid && !dec_err && (cs_n == '1))); // R11
endmodule

// File: tb/addr_route_decoder_bench.sv
module addr_route_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        addr_valid = 1'b0;
  logic [35:0] addr = '0;
  logic        tgt_valid;
  logic [3:0]  tgt_id;
  logic        dec_err;
  logic [3:0]  cs_n;

  addr_route_decoder u_addr_route_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .addr_valid(addr_valid), .addr(addr),
    .tgt_valid(tgt_valid), .tgt_id(tgt_id), .dec_err(dec_err), .cs_n(cs_n)
  );

  always #10 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [3:0]  m_hi [8];
  logic [19:0] m_lo [8];
  logic        m_en [8];
  int          m_sz [8];
  logic [3:0]  m_tid[8];
  logic        m_bv [4];
  logic [23:0] m_bb [4];
  logic [15:0] m_bm [4];
  logic        e_tv = 1'b0;
  logic        e_err = 1'b0;
  logic [3:0]  e_tid = '0;
  logic [3:0]  e_cs = 4'hF;

  function automatic bit win_hit(int w, logic [35:0] a);
    int k;
    logic [35:0] b;
    k = (m_sz[w] < 12) ? 12 : m_sz[w];
    b = {m_hi[w], m_lo[w], 12'h000};
    return m_en[w] && ((a >> k) == (b >> k));
  endfunction

  function automatic bit bank_hit(int n, logic [35:0] a);
    return m_bv[n] && (a[31:24] == m_bb[n][23:16]) &&
           (((a[23:8] ^ m_bb[n][15:0]) & m_bm[n]) == 16'h0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_hi[i] = 0; m_lo[i] = 0; m_en[i] = 0; m_sz[i] = 0; m_tid[i] = 0;
      end
      for (int i = 0; i < 4; i++) begin
        m_bv[i] = 0; m_bb[i] = 0; m_bm[i] = 0;
      end
      e_tv = 0; e_err = 0; e_tid = 0; e_cs = 4'hF;
    end else begin
      int hw, hb;
      e_tv = 0; e_err = 0; e_tid = 0; e_cs = 4'hF;
      if (addr_valid) begin
        hw = -1;
        for (int w = 0; w < 8; w++) if (hw < 0 && win_hit(w, addr)) hw = w;
        if (hw < 0) e_err = 1;
        else begin
          e_tv = 1;
          e_tid = m_tid[hw];
          if (m_tid[hw] == 4'd1) begin
            hb = -1;
            for (int n = 0; n < 4; n++) if (hb < 0 && bank_hit(n, addr)) hb = n;
            if (hb >= 0) e_cs[hb] = 1'b0;
          end
        end
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_hi[wr_idx] = wr_data[3:0];
          3'd1: m_lo[wr_idx] = wr_data[19:0];
          3'd2: begin
            m_en[wr_idx] = wr_data[0];
            m_sz[wr_idx] = int'(wr_data[5:1]);
            m_tid[wr_idx] = wr_data[11:8];
          end
          3'd3: if (wr_idx < 4) begin
            m_bv[wr_idx[1:0]] = wr_data[31];
            m_bb[wr_idx[1:0]] = wr_data[23:0];
          end
          3'd4: if (wr_idx < 4) m_bm[wr_idx[1:0]] = wr_data[15:0];
          default: ;
        endcase
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    vectors++;
    if ({tgt_valid, tgt_id, dec_err, cs_n} !== {e_tv, e_tid, e_err, e_cs}) begin
      fails++;
      $display("FAIL %s at %0t: actual tv=%b id=%h err=%b cs_n=%b expected tv=%b id=%h err=%b cs_n=%b",
               cur_req, $time, tgt_valid, tgt_id, dec_err, cs_n, e_tv, e_tid, e_err, e_cs);
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL R11 watchdog: actual cycles=%0d expected below 150000", cycles);
        finish_run();
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [35:0] a);
    @(negedge clk);
    addr_valid = 1; addr = a;
    @(negedge clk);
    addr_valid = 0;
  endtask

  function automatic logic [31:0] attr(logic en, logic [4:0] sz, logic [3:0] tid);
    return {20'h0, tid, 2'b00, sz, en};
  endfunction

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    look(36'h8_0010_0000);
    look(36'h0_0000_0000);

    cur_req = "R12";
    wr(3'd0, 3'd0, 32'h8);  wr(3'd1, 3'd0, 32'h0);       wr(3'd2, 3'd0, attr(1, 28, 1));
    wr(3'd0, 3'd1, 32'h0);  wr(3'd1, 3'd1, 32'h12345);   wr(3'd2, 3'd1, attr(1, 5, 3));
    wr(3'd0, 3'd2, 32'h8);  wr(3'd1, 3'd2, 32'h0);       wr(3'd2, 3'd2, attr(1, 31, 5));
    wr(3'd0, 3'd3, 32'hF);  wr(3'd1, 3'd3, 32'hABCDE);   wr(3'd2, 3'd3, attr(0, 16, 1));
    wr(3'd0, 3'd5, 32'h2);  wr(3'd1, 3'd5, 32'h40000);   wr(3'd2, 3'd5, attr(1, 24, 1));
    wr(3'd3, 3'd0, {1'b1, 7'h0, 24'h00_1000}); wr(3'd4, 3'd0, 32'hF000);
    wr(3'd3, 3'd1, {1'b1, 7'h0, 24'h00_1200}); wr(3'd4, 3'd1, 32'hFF00);
    wr(3'd3, 3'd2, {1'b0, 7'h0, 24'h00_3000}); wr(3'd4, 3'd2, 32'hF000);
    wr(3'd3, 3'd3, {1'b1, 7'h0, 24'h40_0000}); wr(3'd4, 3'd3, 32'h0000);
    wr(3'd3, 3'd4, {1'b1, 7'h0, 24'h05_0000}); wr(3'd4, 3'd4, 32'h0000);
    look(36'h8_0500_0000);  // R12: out-of-range bank write must not alias bank 0

    cur_req = "R2";
    look(36'h8_0000_0000); look(36'h8_0FFF_FFFF); look(36'h9_0000_0000);
    cur_req = "R3";
    look(36'h0_1234_5000); look(36'h0_1234_5FFF); look(36'h0_1234_6000);
    look(36'h0_1234_4FFF); look(36'h2_40FF_FFFF); look(36'h2_4100_0000);
    cur_req = "R5";
    look(36'h8_0123_4567); look(36'h8_1000_0000); look(36'h8_7FFF_FFFF);
    cur_req = "R4";
    look(36'hF_ABCD_E000);
    wr(3'd2, 3'd3, attr(1, 16, 1));
    look(36'hF_ABCD_E000); look(36'hF_ABCD_0000);
    wr(3'd2, 3'd3, attr(0, 16, 1));
    look(36'hF_ABCD_E000);
    cur_req = "R6";
    look(36'h0_0000_0000); look(36'h7_FFFF_FFFF);
    cur_req = "R7";
    look(36'h8_0110_0000); look(36'h8_0010_0000); look(36'h2_4012_3456);
    cur_req = "R8";
    look(36'h8_001F_FFFF); look(36'h8_0020_0000); look(36'h8_0012_00FF);
    cur_req = "R9";
    look(36'h0_1234_5100); look(36'h8_1010_0000);
    cur_req = "R10";
    look(36'h8_0012_3400); look(36'h8_0030_0000);
    wr(3'd3, 3'd0, {1'b0, 7'h0, 24'h00_1000});
    look(36'h8_0012_3400); look(36'h8_0015_0000);
    wr(3'd3, 3'd0, {1'b1, 7'h0, 24'h00_1000});

    cur_req = "R11";
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      addr_valid = 1;
      addr = (i % 2 == 0) ? 36'h8_0010_0000 : 36'h0_0000_0000;
      @(negedge clk);
    end
    addr_valid = 0;
    repeat (3) @(negedge clk);

    cur_req = "R2";
    for (int i = 0; i < 1500; i++) begin
      logic [35:0] pick;
      case ($urandom % 6)
        0: pick = {4'h8, 4'h0, 28'($urandom)};
        1: pick = {4'h8, 32'($urandom)};
        2: pick = {24'h0_1234_5, 12'($urandom)} ^ (36'($urandom % 2) << 12);
        3: pick = {12'h2_40, 24'($urandom)};
        4: pick = {4'hF, 20'hABCDE, 12'($urandom)};
        default: pick = {4'($urandom), 32'($urandom)};
      endcase
      if (i % 100 == 50) wr(3'd2, 3'd3, attr(1'($urandom), 16, 1));
      @(negedge clk);
      addr_valid = ($urandom % 4) != 0;
      addr = pick;
    end
    @(negedge clk);
    addr_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule